// File: doc/BRIEF.md
# Framed Timeslot Bit Inserter

This block sits in the transmit path of an E1-style TDM stream of 32 timeslots, 8 bits each, one bit per clock. It replaces chosen bit positions of the frame with bits taken from a serial data-link source. All other bits pass through untouched. A single-cycle frame-sync pulse aligns an internal frame position counter. The block also tracks the parity of each frame, so insertion can be limited to even frames, odd frames or both.

The configuration inputs are a channel enable, even and odd frame selects, a 5-bit timeslot number and an 8-bit position mask. The block takes them in only on the frame-sync cycle, so one frame never mixes old and new settings. For each selected position the block pulses a request to the source. The source answers with one bit on the cycle after the request, and that bit takes the place of the through-path bit.

Top module: `ts_bit_inserter`

## Requirements
- R1: The bit on `bit_i` in a cycle with `fsync_i` high is frame position 0, which is bit 0 of timeslot 0. Each later cycle is the next position, and position 255 is followed by 0. A `fsync_i` pulse at any point restarts the count at 0.
- R2: Frame position p lies in timeslot p/8 at bit index p%8. Index 0 is the first bit of the slot on the line. The position is selected only when p/8 equals `ts_sel_i` and bit (p%8) of `bit_mask_i` is 1.
- R3: A bit at a position that is not selected leaves on `bit_o` unchanged, 3 cycles after it was presented on `bit_i`.
- R4: While the latched channel enable is 0, `req_o` stays low and every bit passes through unchanged.
- R5: The first frame after reset is even, and frame parity alternates at each `fsync_i` pulse. A position is selected only if `even_en_i` (even frame) or `odd_en_i` (odd frame) was 1 for the current frame.
- R6: For a selected position presented in cycle t, `req_o` is high for exactly cycle t+1. The value on `dl_bit_i` in cycle t+2 then appears on `bit_o` in cycle t+3.
- R7: All configuration inputs are sampled only in the `fsync_i` cycle, and that cycle's position already uses the new values. Changes between pulses have no effect.
- R8: `dl_bit_i` has no effect on `bit_o` in any cycle that did not follow a request.
- R9: After reset, `req_o` and `bit_o` are 0. The latched enable is 0, so nothing is inserted before the first `fsync_i`, whatever the configuration inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync_i | input | 1 | Marks frame position 0 on `bit_i` |
| bit_i | input | 1 | Through-path serial bit |
| chan_en_i | input | 1 | Insertion enable, sampled at frame start |
| even_en_i | input | 1 | Allow insertion in even frames |
| odd_en_i | input | 1 | Allow insertion in odd frames |
| ts_sel_i | input | 5 | Timeslot carrying inserted bits |
| bit_mask_i | input | 8 | Selected bit indices within the timeslot |
| dl_bit_i | input | 1 | Data-link source bit, valid the cycle after a request |
| req_o | output | 1 | One-cycle request for the next source bit |
| bit_o | output | 1 | Merged serial output |

## Verification
Each result has a fixed delay from the input cycle it belongs to. `req_o` follows a selected input by one cycle. The source bit is driven one cycle after that, and `bit_o` shows the merged value three cycles after the input. The bench keeps a short ring of per-cycle expectations (selection, through bit, source bit) indexed by cycle number. At each falling edge it compares `req_o` with the entry one cycle back and `bit_o` with the entry three cycles back, taking the source bit from the previous cycle. Between frame pulses the bench drives random configuration and random source bits, so any leak of those inputs shows up on the ports.

// File: rtl/ts_ins_pkg.sv
package ts_ins_pkg;

    localparam int SLOT_CNT   = 32;
    localparam int SLOT_BITS  = 8;
    localparam int TS_W       = $clog2(SLOT_CNT);
    localparam int BIT_W      = $clog2(SLOT_BITS);
    localparam int FRAME_BITS = SLOT_CNT * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);
    localparam int PIPE_LAT   = 3;

    typedef struct packed {
        logic                 en;
        logic                 even;
        logic                 odd;
        logic [TS_W-1:0]      ts;
        logic [SLOT_BITS-1:0] mask;
    } ins_cfg_t;

endpackage

// File: rtl/ts_ins_timing.sv
module ts_ins_timing
    import ts_ins_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    input  ins_cfg_t         cfg_i,
    output logic [POS_W-1:0] pos_o,
    output logic             par_o,
    output ins_cfg_t         cfg_o
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             cur_par;
        logic             nxt_par;
        ins_cfg_t         cfg;
    } tim_state_t;

    tim_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fsync_i) begin
            pos_o        = '0;
            par_o        = st_q.nxt_par;
            cfg_o        = cfg_i;
            st_d.nxt_par = ~st_q.nxt_par;
        end else begin
            pos_o = st_q.pos;
            par_o = st_q.cur_par;
            cfg_o = st_q.cfg;
        end
        st_d.pos     = (pos_o == POS_LAST) ? '0 : pos_o + 1'b1;
        st_d.cur_par = par_o;
        st_d.cfg     = cfg_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync_i |=> $stable(st_q.cfg));

    // R1
    pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync_i && st_q.pos == POS_LAST) |=> st_q.pos == '0);

    // R5
    par_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |=> st_q.nxt_par != $past(st_q.nxt_par));

endmodule

// File: rtl/ts_ins_select.sv
module ts_ins_select
    import ts_ins_pkg::*;
(
    input  logic [POS_W-1:0] pos_i,
    input  logic             par_i,
    input  ins_cfg_t         cfg_i,
    output logic             sel_o
);

    logic [TS_W-1:0]      slot;
    logic [BIT_W-1:0]     bidx;
    logic [SLOT_BITS-1:0] bit_hot;
    logic                 frame_ok;

    assign slot = pos_i[POS_W-1:BIT_W];
    assign bidx = pos_i[BIT_W-1:0];

    for (genvar g = 0; g < SLOT_BITS; g++) begin : g_decode
        assign bit_hot[g] = (bidx == BIT_W'(g)) && cfg_i.mask[g];
    end

    always_comb begin
        frame_ok = par_i ? cfg_i.odd : cfg_i.even;
        sel_o    = cfg_i.en && frame_ok && (slot == cfg_i.ts) && (|bit_hot);
    end

endmodule

// File: rtl/ts_ins_pipe.sv
module ts_ins_pipe
    import ts_ins_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic bit_i,
    input  logic dl_bit_i,
    output logic req_o,
    output logic bit_o
);

    typedef struct packed {
        logic sel1;
        logic bit1;
        logic sel2;
        logic bit2;
        logic out;
    } pipe_state_t;

    pipe_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sel1 = sel_i;
        st_d.bit1 = bit_i;
        st_d.sel2 = st_q.sel1;
        st_d.bit2 = st_q.bit1;
        st_d.out  = st_q.sel2 ? dl_bit_i : st_q.bit2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.sel1;
    assign bit_o = st_q.out;

    // R6
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> (st_q.sel2 && !$past(st_q.sel2)) || st_q.sel2);

endmodule

// File: rtl/ts_bit_inserter.sv
module ts_bit_inserter
    import ts_ins_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fsync_i,
    input  logic                 bit_i,
    input  logic                 chan_en_i,
    input  logic                 even_en_i,
    input  logic                 odd_en_i,
    input  logic [TS_W-1:0]      ts_sel_i,
    input  logic [SLOT_BITS-1:0] bit_mask_i,
    input  logic                 dl_bit_i,
    output logic                 req_o,
    output logic                 bit_o
);

    ins_cfg_t         cfg_in;
    ins_cfg_t         cfg_act;
    logic [POS_W-1:0] pos;
    logic             par;
    logic             sel;

    always_comb begin
        cfg_in.en   = chan_en_i;
        cfg_in.even = even_en_i;
        cfg_in.odd  = odd_en_i;
        cfg_in.ts   = ts_sel_i;
        cfg_in.mask = bit_mask_i;
    end

    ts_ins_timing u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync_i (fsync_i),
        .cfg_i   (cfg_in),
        .pos_o   (pos),
        .par_o   (par),
        .cfg_o   (cfg_act)
    );

    ts_ins_select u_select (
        .pos_i (pos),
        .par_i (par),
        .cfg_i (cfg_act),
        .sel_o (sel)
    );

    ts_ins_pipe u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel),
        .bit_i    (bit_i),
        .dl_bit_i (dl_bit_i),
        .req_o    (req_o),
        .bit_o    (bit_o)
    );

    localparam int WARM_W = $clog2(PIPE_LAT + 1);

    logic [WARM_W-1:0] warm_d, warm_q;
    logic              warm;

    always_comb begin
        warm_d = warm_q;
        if (warm_q != WARM_W'(PIPE_LAT)) begin
            warm_d = warm_q + 1'b1;
        end
        warm = (warm_q == WARM_W'(PIPE_LAT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else begin
            warm_q <= warm_d;
        end
    end

    // R3
    through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(req_o, 2)) |-> bit_o == $past(bit_i, 3));

    // R6
    insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(req_o, 2)) |-> bit_o == $past(dl_bit_i, 1));

    // R4
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_i && !chan_en_i) |=> !req_o);

    // R2
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_i && bit_mask_i == '0) |=> !req_o);

endmodule

// File: tb/ts_bit_inserter_bench.sv
module ts_bit_inserter_bench;
    import ts_ins_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst_n;
    logic                 fsync_i;
    logic                 bit_i;
    logic                 chan_en_i;
    logic                 even_en_i;
    logic                 odd_en_i;
    logic [TS_W-1:0]      ts_sel_i;
    logic [SLOT_BITS-1:0] bit_mask_i;
    logic                 dl_bit_i;
    logic                 req_o;
    logic                 bit_o;

    ts_bit_inserter u_ts_bit_inserter (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync_i    (fsync_i),
        .bit_i      (bit_i),
        .chan_en_i  (chan_en_i),
        .even_en_i  (even_en_i),
        .odd_en_i   (odd_en_i),
        .ts_sel_i   (ts_sel_i),
        .bit_mask_i (bit_mask_i),
        .dl_bit_i   (dl_bit_i),
        .req_o      (req_o),
        .bit_o      (bit_o)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    string tag    = "R9";

    int                   m_pos  = 0;
    bit                   m_npar = 1'b0;
    bit                   m_en   = 1'b0;
    bit                   m_ev   = 1'b0;
    bit                   m_od   = 1'b0;
    logic [TS_W-1:0]      m_ts   = '0;
    logic [SLOT_BITS-1:0] m_mk   = '0;
    bit                   m_par  = 1'b0;
    bit                   hsel [8];
    bit                   hbit [8];
    bit                   hdl  [8];

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0b expected %0b", req, cyc, act, exp);
        end
    endtask

    task automatic step(input bit f, input bit en, input bit ev, input bit od,
                        input logic [TS_W-1:0] ts, input logic [SLOT_BITS-1:0] mk);
        int  pos;
        bit  sel;
        bit  exp_b;
        @(negedge clk);
        // R6 request timing, R9 reset values
        if (cyc >= 1) check({"R6 req ", tag}, req_o, hsel[(cyc-1) & 7]);
        else          check("R9 req after reset", req_o, 1'b0);
        if (cyc >= PIPE_LAT) begin
            if (hsel[(cyc-3) & 7]) begin
                exp_b = hdl[(cyc-1) & 7];
                check({"R6 inserted bit ", tag}, bit_o, exp_b);
            end else begin
                exp_b = hbit[(cyc-3) & 7];
                check({"R3/R8 through bit ", tag}, bit_o, exp_b);
            end
        end else begin
            check("R9 bit after reset", bit_o, 1'b0);
        end
        fsync_i  = f;
        bit_i    = 1'($urandom);
        dl_bit_i = 1'($urandom);
        if (f) begin
            chan_en_i = en; even_en_i = ev; odd_en_i = od;
            ts_sel_i = ts; bit_mask_i = mk;
        end else begin
            // R7: junk configuration between frame pulses
            chan_en_i  = 1'($urandom);
            even_en_i  = 1'($urandom);
            odd_en_i   = 1'($urandom);
            ts_sel_i   = TS_W'($urandom);
            bit_mask_i = SLOT_BITS'($urandom);
        end
        if (f) begin
            pos    = 0;
            m_par  = m_npar;
            m_npar = ~m_npar;
            m_en = en; m_ev = ev; m_od = od; m_ts = ts; m_mk = mk;
        end else begin
            pos = m_pos;
        end
        sel = m_en && (m_par ? m_od : m_ev) && ((pos / SLOT_BITS) == int'(m_ts))
              && m_mk[pos % SLOT_BITS];
        m_pos = (pos + 1) % FRAME_BITS;
        hsel[cyc & 7] = sel;
        hbit[cyc & 7] = bit_i;
        hdl[cyc & 7]  = dl_bit_i;
        cyc++;
    endtask

    task automatic frame(input bit en, input bit ev, input bit od,
                         input logic [TS_W-1:0] ts, input logic [SLOT_BITS-1:0] mk,
                         input int len);
        step(1'b1, en, ev, od, ts, mk);
        for (int i = 1; i < len; i++) step(1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    function automatic logic [SLOT_BITS-1:0] mask_for(input int ts);
        case (ts)
            0:       return 8'hFF;
            1:       return 8'h01;
            2:       return 8'h00;
            31:      return 8'h80;
            default: return SLOT_BITS'(ts * 29 + 3);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fsync_i = 1'b0; bit_i = 1'b0; dl_bit_i = 1'b0;
        chan_en_i = 1'b0; even_en_i = 1'b0; odd_en_i = 1'b0;
        ts_sel_i = '0; bit_mask_i = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9: no insertion before the first frame pulse
        tag = "R9";
        for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 1'b0, 1'b0, '0, '0);

        // R2: every timeslot with its own mask, both parities allowed
        tag = "R2";
        for (int ts = 0; ts < SLOT_CNT; ts++)
            frame(1'b1, 1'b1, 1'b1, TS_W'(ts), mask_for(ts), FRAME_BITS);

        // R5: each even/odd select combination over two frames
        tag = "R5";
        for (int k = 0; k < 4; k++)
            for (int r = 0; r < 2; r++)
                frame(1'b1, k[0], k[1], TS_W'(7), 8'hA5, FRAME_BITS);

        // R4: channel disabled, full mask
        tag = "R4";
        frame(1'b0, 1'b1, 1'b1, TS_W'(3), 8'hFF, FRAME_BITS);
        frame(1'b0, 1'b1, 1'b1, TS_W'(0), 8'hFF, FRAME_BITS);

        // R1: early frame pulses realign the position count
        tag = "R1";
        frame(1'b1, 1'b1, 1'b1, TS_W'(4), 8'hFF, 100);
        frame(1'b1, 1'b1, 1'b1, TS_W'(12), 8'h3C, 99);
        frame(1'b1, 1'b1, 1'b1, TS_W'(0), 8'hC3, FRAME_BITS);

        // R7: settings only from the pulse cycle, junk in between
        tag = "R7";
        frame(1'b1, 1'b0, 1'b1, TS_W'(31), 8'hFF, FRAME_BITS);
        frame(1'b1, 1'b0, 1'b1, TS_W'(31), 8'hFF, FRAME_BITS);

        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0, '0, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule